// File: doc/BRIEF.md
# Cascadable Serial Width-Code Loader

This block holds the 22-bit width code used by a programmable pulse stage and lets a controller reload it over a three-wire serial link. The link has a serial clock, a serial data line and an enable. While the enable is high, each rising serial clock edge moves one data bit into an input register, most significant bit first. The code presented to the pulse logic does not change while bits arrive. It is copied from the input register only when the enable falls. A pulse already in flight therefore keeps its width, and the new code applies from the next trigger.

Every shift also pushes the oldest bit of the input register out on a serial output, most significant bit first. Several loaders can share clock and enable, with each serial output wired to the next loader's serial input. A chain of N loaders then takes 22·N bits, and the word for the last loader is sent first. A drive-enable output marks the cycles in which the serial output is meaningful, so a pad or a shared line can be tri-stated outside the loading window.

All three serial inputs pass through a synchroniser into the system clock domain before any edge is detected. Every effect therefore trails its raw input edge by a fixed number of system clocks.

Top module: `serial_code_loader`

## Requirements
- R1: While reset is held and right after it is released, `code_o` is all zeros, `ser_dat_o` is 0 and `ser_oe_o` is 0. The input register is also cleared.
- R2: A rising edge of `ser_clk_i` seen while the enable is high shifts the input register one place toward its MSB. The synchronised `ser_dat_i` enters at bit 0, so a 22-bit word sent MSB first ends up with its first bit in bit 21.
- R3: Rising edges of `ser_clk_i` while the enable is low leave the input register unchanged. This is visible on `ser_dat_o` once the enable is raised again.
- R4: `code_o` changes only on a falling edge of the enable. It then takes the input register contents held at that moment, and it holds its value through any number of shifts.
- R5: Whenever `ser_oe_o` is 0, `ser_dat_o` is 0.
- R6: `ser_oe_o` is 1 exactly while the synchronised enable is high.
- R7: While `ser_oe_o` is 1, `ser_dat_o` shows bit 21 of the input register. Shifting a new word therefore emits the previous word MSB first, and two chained loaders end up holding the first and second word sent.
- R8: An enable pulse with no serial clock edges reloads `code_o` with an unchanged value. A pulse with k < 22 edges latches the old contents moved up by k places with the k new bits below them.
- R9: A raw edge on any serial input takes effect SYNC_STAGES+1 system clock edges after the first edge that samples it. With the default of 2 stages, `ser_oe_o` is still 0 after two edges and is 1 after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock, sampled asynchronously |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_en_i | input | 1 | Load enable; shifting allowed while high, code latched on its fall |
| code_o | output | CODE_W | Latched width code |
| ser_dat_o | output | 1 | Serial output, bit 21 of the input register while driven, else 0 |
| ser_oe_o | output | 1 | Drive enable for the serial output |

## Verification
The bench uses the default build: a 22-bit code and two synchroniser stages. This makes full-word loads, the exact three-clock latency of R9 and the MSB-first spill of a previous word directly observable. A second loader is chained behind the first, so a 44-bit transfer shows that each device keeps its own word. A queue-based reference model checks every output on every clock, while targeted checks cover the disabled-clock, empty-pulse and partial-shift cases.

// File: rtl/scl_pkg.sv
package scl_pkg;
    localparam int SCL_CODE_W   = 22;
    localparam int SCL_SYNC_DEF = 2;
    // positions of the serial inputs inside the synchronised vector
    localparam int IDX_CLK = 0;
    localparam int IDX_DAT = 1;
    localparam int IDX_EN  = 2;
    localparam int SYNC_W  = 3;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb stg_d = d_i;
        end else begin : g_many
            always_comb stg_d = {stg_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/scl_edge.sv
module scl_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign prev_o = prev_q;
endmodule

// File: rtl/scl_shreg.sv
module scl_shreg #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         din_i,
    output logic [W-1:0] sreg_o
);
    logic [W-1:0] sreg_d, sreg_q;

    always_comb begin
        sreg_d = sreg_q;
        if (shift_i) sreg_d = {sreg_q[W-2:0], din_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sreg_q <= '0;
        else        sreg_q <= sreg_d;
    end

    assign sreg_o = sreg_q;

    // R3
    sreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(sreg_q));
    // R2
    sreg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (sreg_q[0] == $past(din_i)) && (sreg_q[W-1:1] == $past(sreg_q[W-2:0])));
endmodule

// File: rtl/serial_code_loader.sv
module serial_code_loader #(
    parameter int CODE_W      = scl_pkg::SCL_CODE_W,
    parameter int SYNC_STAGES = scl_pkg::SCL_SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_en_i,
    output logic [CODE_W-1:0] code_o,
    output logic              ser_dat_o,
    output logic              ser_oe_o
);
    import scl_pkg::*;

    localparam int MSB = CODE_W - 1;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              oe;
    } state_t;

    state_t st_d, st_q;

    logic [SYNC_W-1:0] raw_w, sync_w;
    logic [1:0]        prev_w;
    logic [CODE_W-1:0] sreg_w;
    logic              sclk_lvl, sclk_prev, en_lvl, en_prev;
    logic              sclk_rise, en_fall, shift_w;

    assign raw_w[IDX_CLK] = ser_clk_i;
    assign raw_w[IDX_DAT] = ser_dat_i;
    assign raw_w[IDX_EN]  = ser_en_i;

    scl_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_w),
        .q_o  (sync_w)
    );

    scl_edge #(.WIDTH(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i ({sync_w[IDX_EN], sync_w[IDX_CLK]}),
        .prev_o(prev_w)
    );

    assign sclk_lvl  = sync_w[IDX_CLK];
    assign en_lvl    = sync_w[IDX_EN];
    assign sclk_prev = prev_w[0];
    assign en_prev   = prev_w[1];
    assign sclk_rise = sclk_lvl & ~sclk_prev;
    assign en_fall   = en_prev & ~en_lvl;
    assign shift_w   = sclk_rise & en_lvl;

    scl_shreg #(.W(CODE_W)) u_shreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift_i(shift_w),
        .din_i  (sync_w[IDX_DAT]),
        .sreg_o (sreg_w)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oe = en_lvl;
        if (en_fall) st_d.code = sreg_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o    = st_q.code;
    assign ser_oe_o  = st_q.oe;
    assign ser_dat_o = st_q.oe & sreg_w[MSB];

    // R4
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_fall |=> $stable(code_o));
    // R4
    code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> (code_o == $past(sreg_w)));
    // R5
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_oe_o |-> !ser_dat_o);
    // R6
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_oe_o) |-> $past(en_lvl));
    // R6
    oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> !ser_oe_o);
endmodule

// File: tb/serial_code_loader_bench.sv
module serial_code_loader_bench;
    localparam int W = 22;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, sen = 1'b0;
    logic [W-1:0] code_a, code_b;
    logic sdo_a, oe_a, sdo_b, oe_b;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    serial_code_loader #(.CODE_W(W), .SYNC_STAGES(S)) u_serial_code_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_en_i(sen),
        .code_o(code_a), .ser_dat_o(sdo_a), .ser_oe_o(oe_a)
    );

    serial_code_loader #(.CODE_W(W), .SYNC_STAGES(S)) u_chain (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdo_a), .ser_en_i(sen),
        .code_o(code_b), .ser_dat_o(sdo_b), .ser_oe_o(oe_b)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model: delayed views of the raw inputs, behavioural state
    logic [2:0] hist[$];
    logic [W-1:0] m_sreg = '0, m_code = '0;
    logic m_oe = 1'b0;

    function automatic logic [2:0] at(input int idx);
        if (idx < hist.size()) return hist[idx];
        return 3'b000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            m_sreg = '0; m_code = '0; m_oe = 1'b0;
        end else begin
            logic [2:0] lv, pv;
            logic [W-1:0] old_sreg;
            hist.push_front({sen, sdat, sclk});
            if (hist.size() > S + 2) void'(hist.pop_back());
            lv = at(S);
            pv = at(S + 1);
            old_sreg = m_sreg;
            if (lv[0] && !pv[0] && lv[2]) m_sreg = {m_sreg[W-2:0], lv[1]};
            if (pv[2] && !lv[2]) m_code = old_sreg;
            m_oe = lv[2];
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(code_a == m_code, "R4 model code", 32'(code_a), 32'(m_code));
            chk(oe_a == m_oe, "R6 model oe", 32'(oe_a), 32'(m_oe));
            chk(sdo_a == (m_oe & m_sreg[W-1]), "R7 model sdo", 32'(sdo_a), 32'(m_oe & m_sreg[W-1]));
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk) sdat = b;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_en(input logic v);
        @(negedge clk) sen = v;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            cycles++;
            wd++;
            if (wd > 100000) begin
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [W-1:0] wa, wb;
        wa = 22'h2A5C3F;
        wb = 22'h15B0E6;
        repeat (5) @(negedge clk);
        // R1 during reset
        chk(code_a == '0 && sdo_a == 1'b0 && oe_a == 1'b0, "R1 in reset", {code_a, sdo_a, oe_a}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(code_a == '0 && sdo_a == 1'b0 && oe_a == 1'b0, "R1 after release", {code_a, sdo_a, oe_a}, 0);

        // R9: enable latency
        sen = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(oe_a == 1'b0, "R9 oe after 2 edges", 32'(oe_a), 0);
        @(negedge clk);
        chk(oe_a == 1'b1, "R9 oe after 3 edges", 32'(oe_a), 1);
        repeat (3) @(negedge clk);
        chk(oe_a == 1'b1, "R6 oe while enabled", 32'(oe_a), 1);

        // R2 and R7: load word A, old contents are zeros
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk);
            chk(sdo_a == 1'b0, "R7 old zero out", 32'(sdo_a), 0);
            send_bit(wa[i]);
        end
        chk(code_a == '0, "R4 code held during shift", 32'(code_a), 0);
        set_en(1'b0);
        chk(code_a == wa, "R2 word A latched MSB first", 32'(code_a), 32'(wa));
        chk(oe_a == 1'b0 && sdo_a == 1'b0, "R5 quiet when disabled", {oe_a, sdo_a}, 0);

        // R3: clocks with enable low are ignored
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        chk(code_a == wa, "R3 code unchanged", 32'(code_a), 32'(wa));
        set_en(1'b1);
        chk(sdo_a == wa[W-1], "R3 register untouched", 32'(sdo_a), 32'(wa[W-1]));

        // R7: loading B spills A MSB first into the chained loader
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk);
            chk(sdo_a == wa[i], "R7 spill of old word", 32'(sdo_a), 32'(wa[i]));
            send_bit(wb[i]);
        end
        chk(code_a == wa, "R4 code held until fall", 32'(code_a), 32'(wa));
        set_en(1'b0);
        chk(code_a == wb, "R4 word B latched", 32'(code_a), 32'(wb));
        chk(code_b == wa, "R7 chained loader holds A", 32'(code_b), 32'(wa));

        // R8: empty enable pulse
        set_en(1'b1);
        set_en(1'b0);
        chk(code_a == wb, "R8 empty pulse keeps code", 32'(code_a), 32'(wb));

        // R8: partial shift of three bits
        set_en(1'b1);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        set_en(1'b0);
        chk(code_a == {wb[W-4:0], 3'b101}, "R8 partial shift", 32'(code_a), 32'({wb[W-4:0], 3'b101}));

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule